// File: doc/BRIEF.md
# Register-Mapped SPI Master with Event Flags

This block is a byte-wide SPI master that software drives through a small register bus. A write to the data register launches an 8-bit full-duplex exchange on `sck`, `mosi` and `miso`. Clock polarity, clock phase and bit order are selectable. The serial clock comes from the bus clock through a programmable even divider. When the exchange ends, a completion flag is raised and the received byte can be read back.

Three events are latched as status flags: completion, a data write that collides with a running exchange, and a mode fault. A mode fault means the external active-low select input was pulled low while the block was master. A single interrupt output follows a software-clearable flag. Any hardware set of a flag takes priority over a software clear in the same cycle, so no event is lost.

Register offsets on the bus:

- 0: control. Bit 0 is phase, bit 1 is polarity, bit 2 is master enable, bit 3 is LSB-first and bit 4 is interrupt enable.
- 1: divider.
- 2: status (read only). Bit 7 is done, bit 6 is collision, bit 4 is mode fault and bit 0 is busy.
- 3: data. A write transmits; a read returns the received byte.
- 4: interrupt flag, at bit 0.

Reads return data combinationally. A read's side effects happen at the clock edge where `bus_en` is high and `bus_we` is low.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the divider reads 0x08, status reads 0x00, and `irq`, `sck` and `mosi` are all 0.
- R2: With master enable set, a data write when idle starts an exchange. The byte is shifted out while 8 bits from `miso` are shifted in. At the end, status bit 7 is set and the data register reads the received byte.
- R3: The `sck` period is the divider value, rounded down to even, in bus clocks. Values below 8 act as 8. For example, 0x26 gives 38 clocks, 0x27 gives 38 and 0x03 gives 8.
- R4: With phase 0, data is sampled on the leading `sck` edge; with phase 1, on the trailing edge. All four polarity/phase combinations exchange correctly. When idle, `sck` rests at the polarity bit.
- R5: Control bit 3 = 0 shifts MSB first; 1 shifts LSB first, on both `mosi` and `miso`.
- R6: A data write while busy does not disturb the running exchange: the slave still receives the original byte. Status bit 6 is set instead.
- R7: Done and collision clear only through this sequence: a status read while either flag is set, followed by a data-register access.
- R8: With control bit 4 set, the interrupt flag (offset 4 bit 0, and the `irq` pin) sets when done or collision becomes set. Writing 1 to offset 4 bit 0 clears it. With bit 4 clear, `irq` stays 0.
- R9: If `ss_n` is low while master enable is set, the block clears master enable, aborts any exchange with `sck` at idle, and sets status bit 4 without setting done. Status bit 4 clears after a status read that sees it set, followed by a control write.
- R10: If a hardware set of the interrupt flag coincides with a software clear of it, the flag ends up set.
- R11: After an exchange, `mosi` holds the last bit it drove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | External select, active low; low in master mode is a fault |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a software clear of the interrupt flag landing on the exact cycle the hardware sets it. The bench avoids predicting that cycle. It holds a clear write on the bus every cycle, from before the exchange ends until after it. It then watches `irq` at each cycle for the one-cycle pulse that appears only if the set wins. The mode-fault abort is reached by pulling `ss_n` low in the middle of an exchange. Collisions are reached by writing the data register again a few cycles after launch.

// File: rtl/spi_host_ctl.sv
`timescale 1ns/1ps
module spi_host_ctl #(
  parameter int DW      = 8,
  parameter int AW      = 3,
  parameter int DIV_MIN = 8,
  parameter int DIV_RST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  input  logic          ss_n,
  output logic          irq
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);
  localparam int IW    = $clog2(DW) + 1;
  localparam int KW    = IW - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DIV  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_DATA = AW'(3);
  localparam logic [AW-1:0] A_IRQ  = AW'(4);

  logic          ctl_pha, ctl_pol, ctl_mst, ctl_lsb, ctl_ien;
  logic [DW-1:0] div_r, div_eff, half, cnt;
  logic [DW-1:0] tx_sh, rx_sh, rx_nxt, rd_buf;
  logic [EW-1:0] edge_cnt;
  logic [IW-1:0] out_idx;
  logic          busy, done, wcol, modf, arm_df, arm_mf;
  logic          ss_q1, ss_q2, cond_q, irq_r;

  function automatic logic pick(input logic [DW-1:0] b, input logic [IW-1:0] idx, input logic lsb);
    logic [KW-1:0] k;
    k = idx[KW-1:0];
    if (!lsb) k = KW'(DW - 1) - k;
    return b[k];
  endfunction

  wire wr       = bus_en && bus_we;
  wire rd       = bus_en && !bus_we;
  wire wr_ctrl  = wr && bus_addr == A_CTRL;
  wire wr_div   = wr && bus_addr == A_DIV;
  wire rd_stat  = rd && bus_addr == A_STAT;
  wire data_acc = bus_en && bus_addr == A_DATA;
  wire data_wr  = wr && bus_addr == A_DATA;
  wire wr_irq   = wr && bus_addr == A_IRQ;

  assign div_eff = (div_r < DW'(DIV_MIN)) ? DW'(DIV_MIN) : {div_r[DW-1:1], 1'b0};
  assign half    = div_eff >> 1;

  wire tick    = busy && cnt == half - 1'b1;
  wire smp     = ~edge_cnt[0] ^ ctl_pha;
  wire fault   = ctl_mst && !ss_q2;
  wire fin     = tick && !fault && edge_cnt == EW'(EDGES - 1);
  wire start   = data_wr && !busy && ctl_mst && !fault;
  wire coll    = data_wr && busy;
  wire cond    = ctl_ien && (done || wcol);
  wire clr_df  = arm_df && data_acc;

  assign rx_nxt = !smp ? rx_sh : (ctl_lsb ? {miso, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], miso});
  assign irq    = irq_r;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({ctl_ien, ctl_lsb, ctl_mst, ctl_pol, ctl_pha});
      A_DIV:   bus_rdata = div_r;
      A_STAT:  bus_rdata = DW'({done, wcol, 1'b0, modf, 3'b000, busy});
      A_DATA:  bus_rdata = rd_buf;
      A_IRQ:   bus_rdata = DW'(irq_r);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctl_ien, ctl_lsb, ctl_mst, ctl_pol, ctl_pha} <= '0;
      div_r <= DW'(DIV_RST);
      ss_q1 <= 1'b1;
      ss_q2 <= 1'b1;
    end else begin
      ss_q1 <= ss_n;
      ss_q2 <= ss_q1;
      if (wr_div) div_r <= bus_wdata;
      if (wr_ctrl) {ctl_ien, ctl_lsb, ctl_pol, ctl_pha} <=
                   {bus_wdata[4], bus_wdata[3], bus_wdata[1], bus_wdata[0]};
      if (fault) ctl_mst <= 1'b0;
      else if (wr_ctrl) ctl_mst <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sck <= 1'b0; mosi <= 1'b0;
      cnt <= '0; edge_cnt <= '0; out_idx <= '0;
      tx_sh <= '0; rx_sh <= '0; rd_buf <= '0;
    end else if (busy) begin
      if (fault) begin
        busy <= 1'b0;
        sck  <= ctl_pol;
      end else if (tick) begin
        cnt      <= '0;
        sck      <= ~sck;
        edge_cnt <= edge_cnt + 1'b1;
        rx_sh    <= rx_nxt;
        if (!smp && out_idx < IW'(DW)) begin
          mosi    <= pick(tx_sh, out_idx, ctl_lsb);
          out_idx <= out_idx + 1'b1;
        end
        if (fin) begin
          busy   <= 1'b0;
          rd_buf <= rx_nxt;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      sck      <= ctl_pol;
      cnt      <= '0;
      edge_cnt <= '0;
      if (start) begin
        busy  <= 1'b1;
        tx_sh <= bus_wdata;
        rx_sh <= '0;
        if (!ctl_pha) begin
          mosi    <= pick(bus_wdata, '0, ctl_lsb);
          out_idx <= IW'(1);
        end else begin
          out_idx <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; wcol <= 1'b0; modf <= 1'b0;
      arm_df <= 1'b0; arm_mf <= 1'b0;
      cond_q <= 1'b0; irq_r <= 1'b0;
    end else begin
      if (fin) done <= 1'b1;
      else if (clr_df) done <= 1'b0;
      if (coll) wcol <= 1'b1;
      else if (clr_df) wcol <= 1'b0;
      if (rd_stat && (done || wcol)) arm_df <= 1'b1;
      else if (data_acc) arm_df <= 1'b0;
      if (fault) modf <= 1'b1;
      else if (arm_mf && wr_ctrl) modf <= 1'b0;
      if (rd_stat && modf) arm_mf <= 1'b1;
      else if (wr_ctrl) arm_mf <= 1'b0;
      cond_q <= cond;
      if (cond && !cond_q) irq_r <= 1'b1;
      else if (wr_irq && bus_wdata[0]) irq_r <= 1'b0;
    end
  end

  a_r6_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol);
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(ctl_pol)) |-> sck == ctl_pol);
  a_r9_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctl_mst && modf && !busy));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && !cond_q) |=> irq);
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cond));
endmodule

// File: tb/spi_host_ctl_bench.sv
`timescale 1ns/1ps
module spi_host_ctl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck, mosi, irq;
  logic       miso = 1'b0, ss_n = 1'b1;
  int         errors = 0, checks = 0, cycles = 0;

  logic       pol_b = 0, pha_b = 0, lsb_b = 0, s_act = 0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int         s_cnt = 0;

  spi_host_ctl u_spi_host_ctl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .irq(irq));

  always #5 clk = ~clk;

  function automatic logic bpick(input logic [7:0] b, input int i, input logic l);
    return l ? b[i] : b[7-i];
  endfunction

  always @(sck) begin
    if (s_act) begin
      if ((sck != pol_b) ^ pha_b)
        s_rx = lsb_b ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
      else if (s_cnt < 8) begin
        miso = bpick(s_tx, s_cnt, lsb_b);
        s_cnt++;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic lsb, input logic ien);
    pol_b = pol; pha_b = pha; lsb_b = lsb;
    wr(3'd0, {3'b000, ien, lsb, 1'b1, pol, pha});
    idle(2);
  endtask

  task automatic launch(input logic [7:0] tx, input logic [7:0] sl);
    s_tx = sl; s_rx = '0; s_cnt = 0;
    if (!pha_b) begin miso = bpick(sl, 0, lsb_b); s_cnt = 1; end
    s_act = 1;
    wr(3'd3, tx);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input int half);
    launch(tx, sl);
    idle(16 * half + 4);
    s_act = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(3'd1, d); chk(d == 8'h08, "R1 div", d, 8);
    rd(3'd2, d); chk(d == 8'h00, "R1 status", d, 0);
    chk(irq == 0 && sck == 0 && mosi == 0, "R1 pins", {irq, sck, mosi}, 0);
  endtask

  task automatic t_mode(input logic pol, input logic pha, input logic lsb,
                        input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] d;
    logic       last;
    set_mode(pol, pha, lsb, 0);
    xfer(tx, sl, 4);
    chk(s_rx == tx, "R2/R4/R5 slave got byte", s_rx, tx);
    rd(3'd2, d); chk(d == 8'h80, "R2 done bit7", d, 8'h80);
    rd(3'd3, d); chk(d == sl, "R2/R4/R5 received byte", d, sl);
    rd(3'd2, d); chk(d == 8'h00, "R7 cleared", d, 0);
    chk(sck == pol, "R4 idle sck", sck, pol);
    last = lsb ? tx[7] : tx[0];
    chk(mosi == last, "R11 mosi holds", mosi, last);
  endtask

  task automatic t_div(input logic [7:0] dv, input int exp);
    time t0;
    int  per;
    set_mode(0, 0, 0, 0);
    wr(3'd1, dv);
    launch(8'h5A, 8'h00);
    @(posedge sck); t0 = $time;
    @(posedge sck); per = int'(($time - t0) / 10);
    chk(per == exp, "R3 sck period", per, exp);
    idle(16 * exp / 2 + 4);
    s_act = 0;
    begin logic [7:0] d; rd(3'd2, d); rd(3'd3, d); end
    wr(3'd1, 8'h08);
  endtask

  task automatic t_coll;
    logic [7:0] d;
    set_mode(0, 0, 0, 0);
    launch(8'hA5, 8'h3C);
    idle(10);
    wr(3'd3, 8'hFF);
    idle(16 * 4);
    s_act = 0;
    chk(s_rx == 8'hA5, "R6 transfer undisturbed", s_rx, 8'hA5);
    rd(3'd2, d); chk(d == 8'hC0, "R6 collision bit6", d, 8'hC0);
    rd(3'd3, d); chk(d == 8'h3C, "R6 rx byte", d, 8'h3C);
    rd(3'd2, d); chk(d == 8'h00, "R7 both cleared", d, 0);
  endtask

  task automatic t_clear_seq;
    logic [7:0] d;
    set_mode(0, 1, 0, 0);
    xfer(8'h11, 8'h96, 4);
    rd(3'd3, d); chk(d == 8'h96, "R7 data read", d, 8'h96);
    rd(3'd2, d); chk(d == 8'h80, "R7 unarmed access keeps done", d, 8'h80);
    rd(3'd3, d);
    rd(3'd2, d); chk(d == 8'h00, "R7 armed access clears", d, 0);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    set_mode(0, 0, 0, 1);
    xfer(8'h42, 8'h24, 4);
    chk(irq == 1, "R8 irq on done", irq, 1);
    rd(3'd4, d); chk(d == 8'h01, "R8 flag reg", d, 1);
    wr(3'd4, 8'h01);
    chk(irq == 0, "R8 write-one clear", irq, 0);
    rd(3'd2, d); rd(3'd3, d);
    set_mode(0, 0, 0, 0);
    xfer(8'h42, 8'h24, 4);
    chk(irq == 0, "R8 disabled no irq", irq, 0);
    rd(3'd2, d); rd(3'd3, d);
  endtask

  task automatic t_setwins;
    logic [7:0] d;
    logic       seen;
    seen = 0;
    set_mode(0, 0, 0, 1);
    launch(8'hC3, 8'h5A);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 3'd4; bus_wdata = 8'h01;
    repeat (16 * 4 + 10) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    bus_en = 0; bus_we = 0;
    s_act = 0;
    chk(seen == 1, "R10 set beats clear", seen, 1);
    idle(1);
    chk(irq == 0, "R10 later clear works", irq, 0);
    rd(3'd2, d); rd(3'd3, d);
    set_mode(0, 0, 0, 0);
  endtask

  task automatic t_modf;
    logic [7:0] d;
    set_mode(1, 0, 0, 0);
    launch(8'hF0, 8'h0F);
    idle(12);
    ss_n = 0;
    idle(5);
    chk(sck == 1, "R9 sck to idle", sck, 1);
    idle(16 * 4);
    s_act = 0;
    rd(3'd2, d); chk(d == 8'h10, "R9 fault flag, no done", d, 8'h10);
    rd(3'd0, d); chk(d[2] == 0, "R9 master cleared", d, 8'h02);
    ss_n = 1;
    idle(3);
    wr(3'd0, 8'h04);
    rd(3'd2, d); chk(d == 8'h00, "R9 fault cleared", d, 0);
    rd(3'd0, d); chk(d == 8'h04, "R9 master back", d, 8'h04);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_mode(0, 0, 0, 8'hB1, 8'h6D);
    t_mode(0, 1, 0, 8'h37, 8'hE2);
    t_mode(1, 0, 0, 8'h80, 8'h01);
    t_mode(1, 1, 0, 8'h5C, 8'hA3);
    t_mode(0, 0, 1, 8'hB1, 8'h6D);
    t_mode(1, 1, 1, 8'h0E, 8'hC8);
    t_div(8'h26, 38);
    t_div(8'h27, 38);
    t_div(8'h03, 8);
    t_coll();
    t_clear_seq();
    t_irq();
    t_setwins();
    t_modf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule